// File: doc/BRIEF.md
# Four-Level Interrupt Priority Controller

This block sits next to a microcontroller core and chooses which of its interrupt request lines is served next. Every source has its own enable, and one global enable sits above them all. Two configuration bits per source, a high bit and a low bit, put the source at one of four urgency levels. Each line is set up either as level-sensitive, where its pending state follows the line, or as edge-sensitive, where a rising edge is held until the core acknowledges it.

The controller keeps a mask with one bit for each level that is currently in service. A pending request is offered to the core only when nothing is in service or when its level is strictly above the highest level in service. The core accepts the offered request with a one-cycle acknowledge, which pushes that level into the mask. It ends a handler with an end-of-interrupt pulse, which pops the highest level in service. When several sources are eligible, the highest level wins. Among sources at that same level, the lowest index wins.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0 and `isr_mask` is 0.
- R2: While `glob_en` is 0, `irq_req` stays 0 whatever the sources and their enables are.
- R3: A source whose `src_en` bit is 0 never wins arbitration.
- R4: A source's level is {`prio_hi[i]`, `prio_lo[i]`}, with the high bit as MSB, so hi=1 and lo=0 is level 2. Level 0 is the lowest and level 3 the highest. `irq_lvl` reports the level of the offered source, and `irq_vec` reports its index.
- R5: When eligible sources sit at different levels, the source with the highest level is offered.
- R6: When eligible sources share the highest level, the source with the lowest index is offered.
- R7: While `isr_mask` is not 0, a request is offered only if its level is strictly greater than the highest set bit of `isr_mask`. A request at an equal or lower level waits.
- R8: While bit 3 of `isr_mask` is set, no request is offered.
- R9: If `ack` is high at a clock edge while `irq_req` is 1, that edge sets bit `irq_lvl` of `isr_mask` and drives `irq_req` to 0.
- R10: An `eoi` pulse clears only the highest set bit of `isr_mask`.
- R11: An edge-sensitive source (`edge_mode[i]`=1) stays pending after a rising edge until it is acknowledged, even if its line returns to 0. A level-sensitive source is pending only while its line is 1.
- R12: The outputs are registered. A change on a level-sensitive line first shows on `irq_req` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| glob_en | input | 1 | Master enable for all sources |
| src_en | input | NUM_SRC | Per-source enable |
| edge_mode | input | NUM_SRC | 1 = edge-sensitive, 0 = level-sensitive |
| prio_hi | input | NUM_SRC | Level MSB per source |
| prio_lo | input | NUM_SRC | Level LSB per source |
| src_in | input | NUM_SRC | Raw request lines |
| ack | input | 1 | Core accepts the offered request |
| eoi | input | 1 | End of interrupt, pops highest in-service level |
| irq_req | output | 1 | Registered request to the core |
| irq_vec | output | IDX_W | Index of the offered source |
| irq_lvl | output | 2 | Level of the offered source |
| isr_mask | output | 4 | In-service levels, one bit per level |

## Verification
The hardest condition to reach from the ports is a request arriving while another level is already in service. To get there, the bench first drives a level-sensitive source and acknowledges it, so that its level is held in `isr_mask` while its line stays high. It then raises a second source at every one of the four levels and checks the strict-greater rule in each of the 16 combinations. Nesting two levels and popping them one at a time shows that end-of-interrupt removes only the top level. Two further sweeps cover arbitration: every source is tried alone at every level, and every pair of sources is tried at every pair of levels.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 1 << LVL_W;
    typedef logic [LVL_W-1:0]   lvl_t;
    typedef logic [NUM_LVL-1:0] lvl_mask_t;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int NUM_SRC = 11,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] edge_mode,
    input  logic               clr_vld,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_SRC-1:0] pend
);
    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] held;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d.prev = src_in;
        for (int i = 0; i < NUM_SRC; i++) begin
            st_d.held[i] = (src_in[i] & ~st_q.prev[i])
                         | (st_q.held[i] & ~(clr_vld && (clr_idx == IDX_W'(i))));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign pend[g] = edge_mode[g] ? st_q.held[g] : src_in[g];

        // R11
        held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.held[g] && !(clr_vld && clr_idx == IDX_W'(g))) |=> st_q.held[g]);
    end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 11,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] elig,
    input  logic [NUM_SRC-1:0] prio_hi,
    input  logic [NUM_SRC-1:0] prio_lo,
    output logic               win_vld,
    output logic [IDX_W-1:0]   win_idx,
    output lvl_t               win_lvl
);
    lvl_t src_lvl [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
        assign src_lvl[g] = {prio_hi[g], prio_lo[g]};
    end

    // Walk from the top index down; ">=" lets a lower index take a tie.
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i] && (!win_vld || src_lvl[i] >= win_lvl)) begin
                win_vld = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = src_lvl[i];
            end
        end
    end
endmodule

// File: rtl/irq_isr.sv
module irq_isr
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  lvl_t      push_lvl,
    input  logic      pop,
    output lvl_mask_t mask,
    output lvl_t      top_lvl,
    output logic      busy
);
    lvl_mask_t mask_d, mask_q;

    always_comb begin
        top_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (mask_q[l]) top_lvl = lvl_t'(l);
        end
        busy = |mask_q;
    end

    always_comb begin
        mask_d = mask_q;
        if (pop && busy) mask_d[top_lvl] = 1'b0;
        if (push)        mask_d[push_lvl] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;

    // R10
    eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && busy) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 11,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glob_en,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] edge_mode,
    input  logic [NUM_SRC-1:0] prio_hi,
    input  logic [NUM_SRC-1:0] prio_lo,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               ack,
    input  logic               eoi,
    output logic               irq_req,
    output logic [IDX_W-1:0]   irq_vec,
    output logic [LVL_W-1:0]   irq_lvl,
    output logic [NUM_LVL-1:0] isr_mask
);
    typedef struct packed {
        logic             req;
        logic [IDX_W-1:0] vec;
        lvl_t             lvl;
    } out_st_t;

    out_st_t            st_d, st_q;
    logic [NUM_SRC-1:0] pend, elig;
    logic               win_vld, busy, ack_ok;
    logic [IDX_W-1:0]   win_idx;
    lvl_t               win_lvl, top_lvl;
    lvl_mask_t          mask;

    assign ack_ok = ack && st_q.req;

    irq_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .edge_mode(edge_mode),
        .clr_vld(ack_ok), .clr_idx(st_q.vec), .pend(pend)
    );

    assign elig = pend & src_en & {NUM_SRC{glob_en}};

    irq_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .elig(elig), .prio_hi(prio_hi), .prio_lo(prio_lo),
        .win_vld(win_vld), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    irq_isr u_isr (
        .clk(clk), .rst_n(rst_n), .push(ack_ok), .push_lvl(st_q.lvl),
        .pop(eoi), .mask(mask), .top_lvl(top_lvl), .busy(busy)
    );

    always_comb begin
        st_d.vec = win_idx;
        st_d.lvl = win_lvl;
        st_d.req = win_vld && (!busy || win_lvl > top_lvl) && !ack_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req  = st_q.req;
    assign irq_vec  = st_q.vec;
    assign irq_lvl  = st_q.lvl;
    assign isr_mask = mask;

    // R2
    glob_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(glob_en));
    // R7
    strict_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ($past(mask) == '0 || irq_lvl > $past(top_lvl)));
    // R8
    top_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[NUM_LVL-1] && !eoi) |=> (!irq_req && $stable(mask)));
    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |=> (!irq_req && mask[$past(irq_lvl)]));
    // R4
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (int'(irq_vec) < NUM_SRC));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
    localparam int CLK_P = 10;
    localparam int N     = 11;
    localparam int IW    = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          glob_en = 1'b1;
    logic [N-1:0]  src_en = '1, edge_mode = '0, prio_hi = '0, prio_lo = '0, src_in = '0;
    logic          ack = 1'b0, eoi = 1'b0;
    logic          irq_req;
    logic [IW-1:0] irq_vec;
    logic [1:0]    irq_lvl;
    logic [3:0]    isr_mask;
    int            checks = 0, errors = 0;
    bit            done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irq_prio_ctrl #(.NUM_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .src_en(src_en),
        .edge_mode(edge_mode), .prio_hi(prio_hi), .prio_lo(prio_lo),
        .src_in(src_in), .ack(ack), .eoi(eoi), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_lvl(irq_lvl), .isr_mask(isr_mask)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_eoi();
        eoi = 1'b1; @(negedge clk); eoi = 1'b0;
    endtask

    task automatic set_lvl(int idx, int lvl);
        prio_hi[idx] = lvl[1];
        prio_lo[idx] = lvl[0];
    endtask

    // Offered request as one number: req, vec, lvl.
    function automatic int pack(logic r, int v, int l);
        return r ? (1000 + v * 10 + l) : 0;
    endfunction

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 req", int'(irq_req), 0);
        chk("R1 mask", int'(isr_mask), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 registered output: not visible before the edge, visible after
        set_lvl(3, 1);
        src_in = N'(1) << 3;
        #1 chk("R12 before edge", int'(irq_req), 0);
        @(negedge clk);
        chk("R12 after edge", pack(irq_req, irq_vec, irq_lvl), pack(1, 3, 1));
        src_in = '0; settle();
        // R11 level source drops with its line
        chk("R11 level drop", int'(irq_req), 0);

        // R4 each source alone at each level
        for (int i = 0; i < N; i++) begin
            for (int l = 0; l < 4; l++) begin
                set_lvl(i, l);
                src_in = N'(1) << i; settle();
                chk("R4 single", pack(irq_req, irq_vec, irq_lvl), pack(1, i, l));
                src_in = '0; settle();
            end
        end

        // R5 R6 every pair at every level pair
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int b = 0; b < 4; b++) begin
                        set_lvl(i, a); set_lvl(j, b);
                        src_in = (N'(1) << i) | (N'(1) << j); settle();
                        if (b > a) chk("R5 pair", pack(irq_req, irq_vec, irq_lvl), pack(1, j, b));
                        else if (a > b) chk("R5 pair", pack(irq_req, irq_vec, irq_lvl), pack(1, i, a));
                        else chk("R6 tie", pack(irq_req, irq_vec, irq_lvl), pack(1, i, a));
                        src_in = '0; settle();
                    end
                end
            end
        end

        // R2 global enable off
        glob_en = 1'b0; src_in = '1; settle();
        chk("R2 global off", int'(irq_req), 0);
        src_in = '0; glob_en = 1'b1; settle();

        // R3 individual enable off: source 0 at level 3 masked, source 4 at level 0 wins
        set_lvl(0, 3); set_lvl(4, 0);
        src_en = ~(N'(1));
        src_in = N'(1) | (N'(1) << 4); settle();
        chk("R3 enable off", pack(irq_req, irq_vec, irq_lvl), pack(1, 4, 0));
        src_in = '0; src_en = '1; settle();

        // R7 R8 R9 preemption sweep: source 0 in service at a, source 1 requests at b
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                set_lvl(0, a); set_lvl(1, b);
                src_in = N'(1); settle();
                pulse_ack();
                chk("R9 req drop", int'(irq_req), 0);
                @(negedge clk);
                chk("R9 mask set", int'(isr_mask), 1 << a);
                src_in = N'(3); settle();
                if (b > a) chk("R7 preempt", pack(irq_req, irq_vec, irq_lvl), pack(1, 1, b));
                else if (a == 3) chk("R8 top hold", int'(irq_req), 0);
                else chk("R7 wait", int'(irq_req), 0);
                src_in = '0; pulse_eoi(); settle();
                chk("R10 clear", int'(isr_mask), 0);
            end
        end

        // R10 nesting: levels 1 then 2 in service, pop one at a time
        set_lvl(2, 1); set_lvl(7, 2);
        src_in = N'(1) << 2; settle(); pulse_ack();
        src_in = (N'(1) << 2) | (N'(1) << 7); settle(); pulse_ack(); @(negedge clk);
        chk("R10 nested", int'(isr_mask), 4'b0110);
        src_in = '0;
        pulse_eoi(); @(negedge clk);
        chk("R10 pop top", int'(isr_mask), 4'b0010);
        pulse_eoi(); @(negedge clk);
        chk("R10 pop last", int'(isr_mask), 0);

        // R11 edge source held after the line falls, cleared by ack
        edge_mode = N'(1) << 5; set_lvl(5, 1);
        src_in = N'(1) << 5; @(negedge clk); src_in = '0; settle();
        chk("R11 edge held", pack(irq_req, irq_vec, irq_lvl), pack(1, 5, 1));
        pulse_ack(); pulse_eoi(); settle();
        chk("R11 edge cleared", int'(irq_req), 0);
        chk("R11 mask empty", int'(isr_mask), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule